// File: doc/BRIEF.md
# AXI to TileLink-UL Request/Response Bridge

This block sits between an AXI4 manager and a TileLink Uncached Lightweight (TL-UL) fabric. It takes single-beat AXI reads and writes, turns each into one channel A request, and turns the matching channel D response back into an AXI write response or a single read beat. Only one transaction is in flight at a time. The bridge does not accept a new AXI request until the channel D response for the current one has been handed to the AXI side.

Writes need the address and data channels together. Both are accepted in the same cycle and sent on as a full-data put. Reads are sent on as a get. The AXI ID becomes the TL source tag, and the source in the response becomes the AXI ID again. The TL error flag becomes an AXI slave-error response. The default widths are a 32-bit address, a 6-bit tag and a 256-bit data path, with sizes 0..5 (log2 of the byte count).

Top module: `axi_tlul_bridge`

## Requirements
- R1: During and after reset, with no AXI request present: `tl_a_valid`, `tl_d_ready`, `axi_b_valid`, `axi_r_valid`, `axi_aw_ready`, `axi_w_ready` and `axi_ar_ready` are all 0.
- R2: A write is accepted only when `axi_aw_valid` and `axi_w_valid` are both high while the bridge is idle. `axi_aw_ready` and `axi_w_ready` are then both high in that same cycle.
- R3: An accepted write appears on channel A with opcode 0 (full-data put). Address, source (from the AW ID), size, data and mask (from the write strobes) are carried across unchanged.
- R4: An accepted read appears on channel A with opcode 4 (get). Address, source (from the AR ID) and size are carried across, data is all zeros and mask is all ones.
- R5: `tl_a_valid` rises on the clock edge after the AXI handshake. It then stays high, with all A fields stable, until the edge where `tl_a_ready` is high, and falls after that edge.
- R6: While a request is being issued or is waiting for its response, `axi_aw_ready`, `axi_w_ready` and `axi_ar_ready` stay low.
- R7: When a write pair and a read are offered in the same idle cycle, only the write is accepted (`axi_ar_ready` low). The read is accepted once the write has completed.
- R8: After a write, a channel D response with opcode 0 drives `axi_b_valid`. `axi_b_id` equals the D source. `axi_b_resp` is 0 when the D error flag is clear and 2 when it is set.
- R9: After a read, a channel D response with opcode 1 drives `axi_r_valid` with `axi_r_id` equal to the D source, `axi_r_data` equal to the D data and `axi_r_last` high. `axi_r_resp` is 0 with the error flag clear, or 2 with it set, and the data is still passed through.
- R10: `tl_d_ready` is high only in a cycle where the matching AXI response is valid and its ready is high. A D response is ignored (no AXI response valid, `tl_d_ready` low) when no transaction is waiting, or when its opcode does not match the pending kind (opcode 1 after a write, opcode 0 after a read).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| axi_aw_valid | input | 1 | Write address valid |
| axi_aw_ready | output | 1 | Write address accepted |
| axi_aw_addr | input | 32 | Write address |
| axi_aw_id | input | 6 | Write transaction ID |
| axi_aw_size | input | 3 | Write size, log2 bytes |
| axi_w_valid | input | 1 | Write data valid |
| axi_w_ready | output | 1 | Write data accepted |
| axi_w_data | input | 256 | Write data |
| axi_w_strb | input | 32 | Write byte strobes |
| axi_b_valid | output | 1 | Write response valid |
| axi_b_ready | input | 1 | Write response taken |
| axi_b_id | output | 6 | Write response ID |
| axi_b_resp | output | 2 | Write response code |
| axi_ar_valid | input | 1 | Read address valid |
| axi_ar_ready | output | 1 | Read address accepted |
| axi_ar_addr | input | 32 | Read address |
| axi_ar_id | input | 6 | Read transaction ID |
| axi_ar_size | input | 3 | Read size, log2 bytes |
| axi_r_valid | output | 1 | Read beat valid |
| axi_r_ready | input | 1 | Read beat taken |
| axi_r_id | output | 6 | Read beat ID |
| axi_r_data | output | 256 | Read data |
| axi_r_resp | output | 2 | Read response code |
| axi_r_last | output | 1 | Last beat marker |
| tl_a_valid | output | 1 | Channel A valid |
| tl_a_ready | input | 1 | Channel A accepted |
| tl_a_opcode | output | 3 | Channel A opcode |
| tl_a_address | output | 32 | Channel A address |
| tl_a_source | output | 6 | Channel A source tag |
| tl_a_size | output | 3 | Channel A size |
| tl_a_data | output | 256 | Channel A data |
| tl_a_mask | output | 32 | Channel A byte mask |
| tl_d_valid | input | 1 | Channel D valid |
| tl_d_ready | output | 1 | Channel D accepted |
| tl_d_opcode | input | 3 | Channel D opcode |
| tl_d_source | input | 6 | Channel D source tag |
| tl_d_data | input | 256 | Channel D data |
| tl_d_error | input | 1 | Channel D error flag |

## Verification
On every cycle the assertions check the following: the paired write readies, write priority over a read, the single-outstanding lockout of all AXI readies, the rise and hold of the channel A request, and that channel D is only acknowledged while a response is awaited. Only the bench's scenarios show the field contents. This covers opcode values, the ID-to-source round trip, strobe-to-mask copying at every size, error-to-response mapping and the rejection of a wrong-kind D response. The bench sweeps every size with both error settings and several hold delays on both sides.

// File: rtl/axtl_pkg.sv
package axtl_pkg;
  typedef enum logic [2:0] {
    A_PUT_FULL = 3'd0,
    A_PUT_PART = 3'd1,
    A_GET      = 3'd4
  } a_op_e;

  typedef enum logic [2:0] {
    D_ACK      = 3'd0,
    D_ACK_DATA = 3'd1
  } d_op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_ISSUE,
    ST_WAIT
  } seq_e;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_SLVERR = 2'b10;
endpackage

// File: rtl/axtl_accept.sv
module axtl_accept (
  input  logic clk,
  input  logic rst,
  input  logic idle,
  input  logic aw_valid,
  input  logic w_valid,
  input  logic ar_valid,
  output logic aw_ready,
  output logic w_ready,
  output logic ar_ready,
  output logic take_wr,
  output logic take_rd
);
  logic wr_pair;

  always_comb begin
    wr_pair  = aw_valid && w_valid;
    take_wr  = idle && wr_pair;
    take_rd  = idle && ar_valid && !wr_pair;
    aw_ready = take_wr;
    w_ready  = take_wr;
    ar_ready = take_rd;
  end

  // R2: address and data channels are taken only as a pair
  assert_pair_R2: assert property (@(posedge clk) disable iff (rst)
    (aw_ready || w_ready) |-> (aw_valid && w_valid && idle));

  // R7: a pending write pair blocks the read
  assert_prio_R7: assert property (@(posedge clk) disable iff (rst)
    (aw_valid && w_valid) |-> !ar_ready);
endmodule

// File: rtl/axtl_seq.sv
module axtl_seq import axtl_pkg::*; (
  input  logic clk,
  input  logic rst,
  input  logic take_wr,
  input  logic take_rd,
  input  logic a_ready,
  input  logic d_fire,
  output logic idle,
  output logic a_valid,
  output logic waiting,
  output logic pend_wr
);
  seq_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      pend_wr <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: if (take_wr || take_rd) begin
          st      <= ST_ISSUE;
          pend_wr <= take_wr;
        end
        ST_ISSUE: if (a_ready) st <= ST_WAIT;
        ST_WAIT:  if (d_fire)  st <= ST_IDLE;
        default:  st <= ST_IDLE;
      endcase
    end
  end

  assign idle    = (st == ST_IDLE);
  assign a_valid = (st == ST_ISSUE);
  assign waiting = (st == ST_WAIT);

  // R6: a response can only complete a transaction that was issued
  assert_fire_in_wait_R6: assert property (@(posedge clk) disable iff (rst)
    d_fire |-> waiting);
endmodule

// File: rtl/axtl_a_chan.sv
module axtl_a_chan import axtl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 6,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 256,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take_wr,
  input  logic              take_rd,
  input  logic [ADDR_W-1:0] aw_addr,
  input  logic [ID_W-1:0]   aw_id,
  input  logic [SIZE_W-1:0] aw_size,
  input  logic [DATA_W-1:0] w_data,
  input  logic [MASK_W-1:0] w_strb,
  input  logic [ADDR_W-1:0] ar_addr,
  input  logic [ID_W-1:0]   ar_id,
  input  logic [SIZE_W-1:0] ar_size,
  output logic [2:0]        a_opcode,
  output logic [ADDR_W-1:0] a_address,
  output logic [ID_W-1:0]   a_source,
  output logic [SIZE_W-1:0] a_size,
  output logic [DATA_W-1:0] a_data,
  output logic [MASK_W-1:0] a_mask
);
  always_ff @(posedge clk) begin
    if (rst) begin
      a_opcode  <= 3'd0;
      a_address <= '0;
      a_source  <= '0;
      a_size    <= '0;
      a_data    <= '0;
      a_mask    <= '0;
    end else if (take_wr) begin
      a_opcode  <= A_PUT_FULL;
      a_address <= aw_addr;
      a_source  <= aw_id;
      a_size    <= aw_size;
      a_data    <= w_data;
      a_mask    <= w_strb;
    end else if (take_rd) begin
      a_opcode  <= A_GET;
      a_address <= ar_addr;
      a_source  <= ar_id;
      a_size    <= ar_size;
      a_data    <= '0;
      a_mask    <= '1;
    end
  end

  // R7: the two capture strobes never fire together
  assert_one_take_R7: assert property (@(posedge clk) disable iff (rst)
    !(take_wr && take_rd));
endmodule

// File: rtl/axtl_d_chan.sv
module axtl_d_chan import axtl_pkg::*; #(
  parameter int ID_W   = 6,
  parameter int DATA_W = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              waiting,
  input  logic              pend_wr,
  input  logic              d_valid,
  input  logic [2:0]        d_opcode,
  input  logic [ID_W-1:0]   d_source,
  input  logic [DATA_W-1:0] d_data,
  input  logic              d_error,
  input  logic              b_ready,
  input  logic              r_ready,
  output logic              b_valid,
  output logic [ID_W-1:0]   b_id,
  output logic [1:0]        b_resp,
  output logic              r_valid,
  output logic [ID_W-1:0]   r_id,
  output logic [DATA_W-1:0] r_data,
  output logic [1:0]        r_resp,
  output logic              r_last,
  output logic              d_ready,
  output logic              d_fire
);
  logic [1:0] resp_code;

  always_comb begin
    resp_code = d_error ? RESP_SLVERR : RESP_OKAY;
    b_valid   = waiting && pend_wr  && d_valid && (d_opcode == D_ACK);
    r_valid   = waiting && !pend_wr && d_valid && (d_opcode == D_ACK_DATA);
    b_id      = d_source;
    b_resp    = resp_code;
    r_id      = d_source;
    r_data    = d_data;
    r_resp    = resp_code;
    r_last    = 1'b1;
    d_ready   = (b_valid && b_ready) || (r_valid && r_ready);
    d_fire    = d_ready && d_valid;
  end

  // R10: at most one AXI response channel is offered per cycle
  assert_one_rsp_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({b_valid, r_valid}));
endmodule

// File: rtl/axi_tlul_bridge.sv
module axi_tlul_bridge import axtl_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int ID_W   = 6,
  parameter int SIZE_W = 3,
  parameter int DATA_W = 256,
  localparam int MASK_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              axi_aw_valid,
  output logic              axi_aw_ready,
  input  logic [ADDR_W-1:0] axi_aw_addr,
  input  logic [ID_W-1:0]   axi_aw_id,
  input  logic [SIZE_W-1:0] axi_aw_size,
  input  logic              axi_w_valid,
  output logic              axi_w_ready,
  input  logic [DATA_W-1:0] axi_w_data,
  input  logic [MASK_W-1:0] axi_w_strb,
  output logic              axi_b_valid,
  input  logic              axi_b_ready,
  output logic [ID_W-1:0]   axi_b_id,
  output logic [1:0]        axi_b_resp,
  input  logic              axi_ar_valid,
  output logic              axi_ar_ready,
  input  logic [ADDR_W-1:0] axi_ar_addr,
  input  logic [ID_W-1:0]   axi_ar_id,
  input  logic [SIZE_W-1:0] axi_ar_size,
  output logic              axi_r_valid,
  input  logic              axi_r_ready,
  output logic [ID_W-1:0]   axi_r_id,
  output logic [DATA_W-1:0] axi_r_data,
  output logic [1:0]        axi_r_resp,
  output logic              axi_r_last,
  output logic              tl_a_valid,
  input  logic              tl_a_ready,
  output logic [2:0]        tl_a_opcode,
  output logic [ADDR_W-1:0] tl_a_address,
  output logic [ID_W-1:0]   tl_a_source,
  output logic [SIZE_W-1:0] tl_a_size,
  output logic [DATA_W-1:0] tl_a_data,
  output logic [MASK_W-1:0] tl_a_mask,
  input  logic              tl_d_valid,
  output logic              tl_d_ready,
  input  logic [2:0]        tl_d_opcode,
  input  logic [ID_W-1:0]   tl_d_source,
  input  logic [DATA_W-1:0] tl_d_data,
  input  logic              tl_d_error
);
  logic idle, waiting, pend_wr, take_wr, take_rd, d_fire;

  axtl_accept u_accept (
    .clk      (clk),
    .rst      (rst),
    .idle     (idle),
    .aw_valid (axi_aw_valid),
    .w_valid  (axi_w_valid),
    .ar_valid (axi_ar_valid),
    .aw_ready (axi_aw_ready),
    .w_ready  (axi_w_ready),
    .ar_ready (axi_ar_ready),
    .take_wr  (take_wr),
    .take_rd  (take_rd)
  );

  axtl_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .take_wr (take_wr),
    .take_rd (take_rd),
    .a_ready (tl_a_ready),
    .d_fire  (d_fire),
    .idle    (idle),
    .a_valid (tl_a_valid),
    .waiting (waiting),
    .pend_wr (pend_wr)
  );

  axtl_a_chan #(
    .ADDR_W (ADDR_W),
    .ID_W   (ID_W),
    .SIZE_W (SIZE_W),
    .DATA_W (DATA_W)
  ) u_a_chan (
    .clk       (clk),
    .rst       (rst),
    .take_wr   (take_wr),
    .take_rd   (take_rd),
    .aw_addr   (axi_aw_addr),
    .aw_id     (axi_aw_id),
    .aw_size   (axi_aw_size),
    .w_data    (axi_w_data),
    .w_strb    (axi_w_strb),
    .ar_addr   (axi_ar_addr),
    .ar_id     (axi_ar_id),
    .ar_size   (axi_ar_size),
    .a_opcode  (tl_a_opcode),
    .a_address (tl_a_address),
    .a_source  (tl_a_source),
    .a_size    (tl_a_size),
    .a_data    (tl_a_data),
    .a_mask    (tl_a_mask)
  );

  axtl_d_chan #(
    .ID_W   (ID_W),
    .DATA_W (DATA_W)
  ) u_d_chan (
    .clk      (clk),
    .rst      (rst),
    .waiting  (waiting),
    .pend_wr  (pend_wr),
    .d_valid  (tl_d_valid),
    .d_opcode (tl_d_opcode),
    .d_source (tl_d_source),
    .d_data   (tl_d_data),
    .d_error  (tl_d_error),
    .b_ready  (axi_b_ready),
    .r_ready  (axi_r_ready),
    .b_valid  (axi_b_valid),
    .b_id     (axi_b_id),
    .b_resp   (axi_b_resp),
    .r_valid  (axi_r_valid),
    .r_id     (axi_r_id),
    .r_data   (axi_r_data),
    .r_resp   (axi_r_resp),
    .r_last   (axi_r_last),
    .d_ready  (tl_d_ready),
    .d_fire   (d_fire)
  );

  // R5: a handshake on either AXI request channel raises A on the next edge
  assert_a_rise_R5: assert property (@(posedge clk) disable iff (rst)
    (axi_aw_ready || axi_ar_ready) |=> tl_a_valid);

  // R5: an unaccepted A request holds its contents
  assert_a_hold_R5: assert property (@(posedge clk) disable iff (rst)
    (tl_a_valid && !tl_a_ready) |=> (tl_a_valid && $stable(tl_a_opcode) &&
      $stable(tl_a_address) && $stable(tl_a_source) && $stable(tl_a_size) &&
      $stable(tl_a_mask)));

  // R6: no new request while one is in flight
  assert_single_R6: assert property (@(posedge clk) disable iff (rst)
    (tl_a_valid || waiting) |-> (!axi_aw_ready && !axi_w_ready && !axi_ar_ready));

  // R10: D is acknowledged only while a response is awaited
  assert_dready_R10: assert property (@(posedge clk) disable iff (rst)
    tl_d_ready |-> (waiting && tl_d_valid));
endmodule

// File: tb/sim_axi_tlul_bridge.sv
module sim_axi_tlul_bridge;
  localparam int AW = 32, IW = 6, SW = 3, DW = 256, BW = DW / 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst;
  logic aw_valid, aw_ready, w_valid, w_ready, b_valid, b_ready;
  logic ar_valid, ar_ready, r_valid, r_ready, r_last;
  logic [AW-1:0] aw_addr, ar_addr, a_address;
  logic [IW-1:0] aw_id, ar_id, b_id, r_id, a_source, d_source;
  logic [SW-1:0] aw_size, ar_size, a_size;
  logic [DW-1:0] w_data, r_data, a_data, d_data;
  logic [BW-1:0] w_strb, a_mask;
  logic [1:0]    b_resp, r_resp;
  logic          a_valid, a_ready, d_valid, d_ready, d_error;
  logic [2:0]    a_opcode, d_opcode;

  axi_tlul_bridge u0 (
    .clk(clk), .rst(rst),
    .axi_aw_valid(aw_valid), .axi_aw_ready(aw_ready), .axi_aw_addr(aw_addr),
    .axi_aw_id(aw_id), .axi_aw_size(aw_size),
    .axi_w_valid(w_valid), .axi_w_ready(w_ready), .axi_w_data(w_data), .axi_w_strb(w_strb),
    .axi_b_valid(b_valid), .axi_b_ready(b_ready), .axi_b_id(b_id), .axi_b_resp(b_resp),
    .axi_ar_valid(ar_valid), .axi_ar_ready(ar_ready), .axi_ar_addr(ar_addr),
    .axi_ar_id(ar_id), .axi_ar_size(ar_size),
    .axi_r_valid(r_valid), .axi_r_ready(r_ready), .axi_r_id(r_id), .axi_r_data(r_data),
    .axi_r_resp(r_resp), .axi_r_last(r_last),
    .tl_a_valid(a_valid), .tl_a_ready(a_ready), .tl_a_opcode(a_opcode),
    .tl_a_address(a_address), .tl_a_source(a_source), .tl_a_size(a_size),
    .tl_a_data(a_data), .tl_a_mask(a_mask),
    .tl_d_valid(d_valid), .tl_d_ready(d_ready), .tl_d_opcode(d_opcode),
    .tl_d_source(d_source), .tl_d_data(d_data), .tl_d_error(d_error)
  );

  int n_cmp = 0;
  int n_bad = 0;

  task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mkdata(int k);
    return {8{(32'h9E3779B9 * 32'(k + 1)) ^ 32'(k)}};
  endfunction

  function automatic logic [AW-1:0] mkaddr(int id, int sz);
    return 32'(id) * 32'h0101_0040 + 32'(sz) * 32'h10 + 32'h8000_0000;
  endfunction

  function automatic logic [BW-1:0] mkstrb(int sz);
    logic [63:0] m;
    m = (64'd1 << (1 << sz)) - 64'd1;
    return m[BW-1:0];
  endfunction

  task automatic do_write(int id, int sz, int adly, int bdly, bit err, bit ar_too);
    logic [AW-1:0] ad;
    logic [DW-1:0] dt;
    logic [BW-1:0] sb;
    ad = mkaddr(id, sz);
    dt = mkdata(id * 11 + sz);
    sb = mkstrb(sz);
    @(negedge clk);
    aw_valid = 1; w_valid = 1;
    aw_addr = ad; aw_id = IW'(id); aw_size = SW'(sz); w_data = dt; w_strb = sb;
    if (ar_too) begin
      ar_valid = 1; ar_addr = ~ad; ar_id = IW'(id ^ 1); ar_size = SW'(sz);
    end
    #1;
    chk("R2 aw_ready with pair", aw_ready, 1);
    chk("R2 w_ready with pair", w_ready, 1);
    if (ar_too) chk("R7 ar_ready blocked by write", ar_ready, 0);
    @(negedge clk);
    aw_valid = 0; w_valid = 0;
    #1;
    chk("R5 a_valid after handshake", a_valid, 1);
    chk("R3 opcode put", a_opcode, 0);
    chk("R3 address", a_address, ad);
    chk("R3 source", a_source, id);
    chk("R3 size", a_size, sz);
    chk("R3 data", a_data, dt);
    chk("R3 mask", a_mask, sb);
    if (ar_too) chk("R6 ar_ready while busy", ar_ready, 0);
    for (int i = 0; i < adly; i++) begin
      @(negedge clk);
      aw_valid = 1; w_valid = 1; aw_addr = ~ad;
      #1;
      chk("R5 a_valid held", a_valid, 1);
      chk("R5 address held", a_address, ad);
      chk("R6 aw_ready while issuing", aw_ready, 0);
    end
    @(negedge clk);
    aw_valid = 0; w_valid = 0; a_ready = 1;
    @(negedge clk);
    a_ready = 0;
    d_valid = 1; d_opcode = 3'd1; d_source = IW'(id); d_error = err; d_data = mkdata(7);
    r_ready = 1; b_ready = 0;
    #1;
    chk("R5 a_valid drops after accept", a_valid, 0);
    chk("R10 wrong-kind D gives no r_valid", r_valid, 0);
    chk("R10 wrong-kind D not acknowledged", d_ready, 0);
    if (ar_too) chk("R6 ar_ready while waiting", ar_ready, 0);
    @(negedge clk);
    d_opcode = 3'd0; r_ready = 0;
    #1;
    chk("R8 b_valid", b_valid, 1);
    chk("R8 b_id", b_id, id);
    chk("R8 b_resp", b_resp, err ? 2 : 0);
    chk("R10 d_ready without b_ready", d_ready, 0);
    for (int i = 0; i < bdly; i++) begin
      @(negedge clk);
      #1;
      chk("R10 d_ready held off", d_ready, 0);
      chk("R8 b_valid held", b_valid, 1);
    end
    @(negedge clk);
    b_ready = 1;
    #1;
    chk("R10 d_ready with b_ready", d_ready, 1);
    @(negedge clk);
    d_valid = 0; b_ready = 0;
    #1;
    chk("R8 b_valid cleared", b_valid, 0);
    if (ar_too) begin
      chk("R7 read taken after write", ar_ready, 1);
      ar_valid = 0;
    end
  endtask

  task automatic do_read(int id, int sz, int adly, int rdly, bit err);
    logic [AW-1:0] ad;
    logic [DW-1:0] dt;
    ad = mkaddr(id, sz) ^ 32'h0000_F000;
    dt = mkdata(id + sz * 5 + 100);
    @(negedge clk);
    ar_valid = 1; ar_addr = ad; ar_id = IW'(id); ar_size = SW'(sz);
    #1;
    chk("R4 ar_ready idle", ar_ready, 1);
    chk("R2 aw_ready without pair", aw_ready, 0);
    @(negedge clk);
    ar_valid = 0;
    #1;
    chk("R5 a_valid after read handshake", a_valid, 1);
    chk("R4 opcode get", a_opcode, 4);
    chk("R4 address", a_address, ad);
    chk("R4 source", a_source, id);
    chk("R4 size", a_size, sz);
    chk("R4 data zero", a_data, 0);
    chk("R4 mask ones", a_mask, {BW{1'b1}});
    for (int i = 0; i < adly; i++) begin
      @(negedge clk);
      ar_valid = 1; ar_addr = ~ad;
      #1;
      chk("R5 a_valid held", a_valid, 1);
      chk("R5 source held", a_source, id);
      chk("R6 ar_ready while issuing", ar_ready, 0);
    end
    @(negedge clk);
    ar_valid = 0; a_ready = 1;
    @(negedge clk);
    a_ready = 0;
    d_valid = 1; d_opcode = 3'd0; d_source = IW'(id); d_error = err; d_data = dt;
    b_ready = 1; r_ready = 0;
    #1;
    chk("R10 wrong-kind D gives no b_valid", b_valid, 0);
    chk("R10 wrong-kind D not acknowledged", d_ready, 0);
    @(negedge clk);
    d_opcode = 3'd1; b_ready = 0;
    #1;
    chk("R9 r_valid", r_valid, 1);
    chk("R9 r_id", r_id, id);
    chk("R9 r_data", r_data, dt);
    chk("R9 r_resp", r_resp, err ? 2 : 0);
    chk("R9 r_last", r_last, 1);
    chk("R10 d_ready without r_ready", d_ready, 0);
    for (int i = 0; i < rdly; i++) begin
      @(negedge clk);
      #1;
      chk("R10 d_ready held off", d_ready, 0);
    end
    @(negedge clk);
    r_ready = 1;
    #1;
    chk("R10 d_ready with r_ready", d_ready, 1);
    @(negedge clk);
    d_valid = 0; r_ready = 0;
    #1;
    chk("R9 r_valid cleared", r_valid, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst = 1;
    aw_valid = 0; w_valid = 0; ar_valid = 0; b_ready = 0; r_ready = 0;
    a_ready = 0; d_valid = 0; d_opcode = 0; d_source = 0; d_data = 0; d_error = 0;
    aw_addr = 0; aw_id = 0; aw_size = 0; w_data = 0; w_strb = 0;
    ar_addr = 0; ar_id = 0; ar_size = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 a_valid in reset", a_valid, 0);
    chk("R1 d_ready in reset", d_ready, 0);
    @(negedge clk);
    rst = 0;
    #1;
    chk("R1 a_valid after reset", a_valid, 0);
    chk("R1 b_valid after reset", b_valid, 0);
    chk("R1 r_valid after reset", r_valid, 0);
    chk("R1 aw_ready after reset", aw_ready, 0);
    chk("R1 w_ready after reset", w_ready, 0);
    chk("R1 ar_ready after reset", ar_ready, 0);
    // R10: D with nothing outstanding is ignored
    @(negedge clk);
    d_valid = 1; d_opcode = 3'd1; b_ready = 1; r_ready = 1;
    #1;
    chk("R10 idle D no r_valid", r_valid, 0);
    chk("R10 idle D no d_ready", d_ready, 0);
    d_opcode = 3'd0;
    #1;
    chk("R10 idle D no b_valid", b_valid, 0);
    @(negedge clk);
    d_valid = 0; b_ready = 0; r_ready = 0;
    // R2: address without data is not accepted
    aw_valid = 1;
    #1;
    chk("R2 aw alone not accepted", aw_ready, 0);
    @(negedge clk);
    aw_valid = 0; w_valid = 1;
    #1;
    chk("R2 w alone not accepted", w_ready, 0);
    @(negedge clk);
    w_valid = 0;
    for (int sz = 0; sz <= 5; sz++) begin
      for (int e = 0; e < 2; e++) begin
        do_write((sz * 13 + e * 29) % 64, sz, (sz + e) % 3, sz % 2, e[0], 1'b0);
        do_read((sz * 17 + e * 5 + 1) % 64, sz, (sz + 2 * e) % 3, (sz + e) % 2, e[0]);
      end
    end
    do_write(0, 0, 0, 0, 1'b0, 1'b0);
    do_read(63, 5, 1, 1, 1'b1);
    do_write(63, 5, 2, 2, 1'b1, 1'b1);
    do_read(62, 5, 0, 0, 1'b0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule